// File: doc/BRIEF.md
# Stretching Converter Read Sequencer

This block is the read-side controller of a two-wire serial analog-to-digital converter whose conversions are paced by an on-chip clock. It works from bus events that a separate front end has already decoded (START, STOP, rising and falling SCL edges, and the sampled SDA level). When the master addresses the device for reading, the block acknowledges. From the falling edge that ends the acknowledge bit, it pulls SCL low and runs a scan of one or more channels on a converter model. That model takes a start pulse and answers with a done pulse and an 8-bit result.

Every result goes into the next location of a small result store. After the last conversion has been stored, SCL is let go and the master clocks the results out, most significant bit first, in the order they were converted. If the master keeps acknowledging past the final result, readback wraps to the first result. A not-acknowledge makes the block let go of SDA until the next START. Fresh results are made only by a new read addressing. The channel that can double as a reference pin is always the highest channel, and it is left out of multi-channel scans while it is in reference use.

Top module: `stretch_read_seq`

## Requirements
- R1: The block pulls SDA low in the acknowledge slot only when the 8 bits clocked in after a START are DEV_ADDR (sent MSB first) followed by a 1. Any other address or a 0 in the eighth bit gets no acknowledge, no SCL stretch and no conversion.
- R2: scl_hold is high in the cycle after the falling SCL event that ends the acknowledge slot. It stays high through every conversion of the scan and goes low only in the cycle after the last result has been written.
- R3: Each cnv_start is a one-cycle pulse. It comes TRACK_CYC clock cycles after the clock edge that took in the ninth falling SCL event (first channel) or the cnv_done of the previous channel (later channels). Only one conversion is ever in flight.
- R4: cfg_scan selects the scan. 2'b00 converts channels 0 up to cfg_sel. 2'b01 converts cfg_sel up to NCH-1. 2'b10 and 2'b11 convert cfg_sel alone. Channels are converted in ascending order, and cnv_chan carries the channel number during cnv_start.
- R5: When cfg_ref_on is 1, channel NCH-1 is dropped from any scan that would convert more than one channel. A single conversion of NCH-1 is still made.
- R6: The result of the k-th conversion is the k-th byte read. It is sent MSB first, with sda_low = 1 meaning a 0 bit. The MSB of the first byte is on SDA when scl_hold goes low, and each following bit appears after a falling SCL event.
- R7: An acknowledged read after the last stored result returns the first result again, and the sequence goes on from there.
- R8: After a not-acknowledge from the master, sda_low stays 0 through further SCL activity until the next START.
- R9: Every new read transaction reads from the first entry, with the results of that transaction's own scan.
- R10: Reset drives scl_hold, sda_low and cnv_start to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_start | input | 1 | One-cycle pulse: START or repeated START seen |
| ev_stop | input | 1 | One-cycle pulse: STOP seen |
| ev_scl_rise | input | 1 | One-cycle pulse: SCL rose, sda_in valid |
| ev_scl_fall | input | 1 | One-cycle pulse: SCL fell |
| sda_in | input | 1 | SDA level sampled at the SCL rise |
| cfg_sel | input | $clog2(NCH) | Channel select used by the scan |
| cfg_scan | input | 2 | Scan kind (see R4) |
| cfg_ref_on | input | 1 | Top channel is in reference use |
| scl_hold | output | 1 | 1 = pull SCL low (stretch) |
| sda_low | output | 1 | 1 = pull SDA low |
| cnv_start | output | 1 | Converter start pulse |
| cnv_chan | output | $clog2(NCH) | Channel to convert |
| cnv_done | input | 1 | Converter result valid pulse |
| cnv_data | input | 8 | Converter result |

## Verification
A wrong channel counter shows on cnv_chan at the next cnv_start, at most TRACK_CYC cycles after the previous done. A sequencer that stalls or ends too early shows as scl_hold staying high, or falling while a conversion is still open. A bad read pointer or shift register shows in the first SDA bit after the acknowledge fall. The bench checks the full channel sequence and every byte it reads, including bytes read after a wrap, so a fault shows up within one byte of where it happens.

// File: rtl/srs_pkg.sv
// Shared types for the stretching read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package srs_pkg;
    typedef enum logic [2:0] {
        BS_IDLE, BS_ADDR, BS_AACK, BS_CONV, BS_READ, BS_PARK
    } bus_st_t;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_TRACK, SQ_WAIT
    } seq_st_t;

    localparam logic [1:0] SCAN_UP  = 2'b00;
    localparam logic [1:0] SCAN_TOP = 2'b01;
endpackage

// File: rtl/srs_scan_seq.sv
// Scan sequencer: on go it steps from first_ch to last_ch. For each channel it
// waits TRACK_CYC cycles, pulses cnv_start, waits for cnv_done and writes the
// result to the next store slot. fin pulses in the cycle after the last write.
// Assumes: cnv_done comes only after cnv_start; first_ch <= last_ch.
module srs_scan_seq
    import srs_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int TRACK_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    abort,
    input  logic                    go,
    input  logic [$clog2(NCH)-1:0]  first_ch,
    input  logic [$clog2(NCH)-1:0]  last_ch,
    output logic                    cnv_start,
    output logic [$clog2(NCH)-1:0]  cnv_chan,
    input  logic                    cnv_done,
    input  logic [7:0]              cnv_data,
    output logic                    wr_en,
    output logic [$clog2(NCH)-1:0]  wr_addr,
    output logic [7:0]              wr_data,
    output logic                    fin
);
    localparam int CHW = $clog2(NCH);
    localparam int TW  = $clog2(TRACK_CYC + 1);

    seq_st_t          st;
    logic [CHW-1:0]   ch, last_q, idx;
    logic [TW-1:0]    tmr;

    // Step through tracking, conversion and storing for each channel.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            st        <= SQ_IDLE;
            ch        <= '0;
            last_q    <= '0;
            idx       <= '0;
            tmr       <= '0;
            cnv_start <= 1'b0;
            fin       <= 1'b0;
        end else begin
            cnv_start <= 1'b0;
            fin       <= 1'b0;
            case (st)
                SQ_IDLE: if (go) begin
                    ch     <= first_ch;
                    last_q <= last_ch;
                    idx    <= '0;
                    tmr    <= '0;
                    st     <= SQ_TRACK;
                end
                SQ_TRACK: begin
                    if (tmr == TW'(TRACK_CYC - 1)) begin
                        cnv_start <= 1'b1;
                        st        <= SQ_WAIT;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                SQ_WAIT: if (cnv_done) begin
                    if (ch == last_q) begin
                        fin <= 1'b1;
                        st  <= SQ_IDLE;
                    end else begin
                        ch  <= ch + 1'b1;
                        idx <= idx + 1'b1;
                        tmr <= '0;
                        st  <= SQ_TRACK;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Route the converter result into the store at the running index.
    always_comb begin
        wr_en    = (st == SQ_WAIT) && cnv_done;
        wr_addr  = idx;
        wr_data  = cnv_data;
        cnv_chan = ch;
    end
endmodule

// File: rtl/srs_result_ram.sv
// Result store: DEPTH bytes, one synchronous write port, one combinational
// read port. Contents are undefined after reset.
// Assumes: wr_addr and rd_addr stay below DEPTH.
module srs_result_ram #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    // Store one result per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the entry under the read pointer.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/stretch_read_seq.sv
// Top: bus-side state machine of the read sequencer. It decodes the address
// byte, acknowledges a read addressed to DEV_ADDR, stretches SCL while
// srs_scan_seq runs the scan, then shifts the stored bytes out MSB first
// with a wrapping read pointer.
// Assumes: the event inputs are one-cycle pulses and never coincide;
// sda_in is valid with ev_scl_rise; channel NCH-1 is the one shared with
// the reference.
module stretch_read_seq
    import srs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h64,
    parameter int         NCH       = 8,
    parameter int         TRACK_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_start,
    input  logic                    ev_stop,
    input  logic                    ev_scl_rise,
    input  logic                    ev_scl_fall,
    input  logic                    sda_in,
    input  logic [$clog2(NCH)-1:0]  cfg_sel,
    input  logic [1:0]              cfg_scan,
    input  logic                    cfg_ref_on,
    output logic                    scl_hold,
    output logic                    sda_low,
    output logic                    cnv_start,
    output logic [$clog2(NCH)-1:0]  cnv_chan,
    input  logic                    cnv_done,
    input  logic [7:0]              cnv_data
);
    localparam int             CHW    = $clog2(NCH);
    localparam logic [CHW-1:0] TOP_CH = CHW'(NCH - 1);

    bus_st_t         bst;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [CHW-1:0]  rd_ptr, rd_last;
    logic            mack;
    logic [CHW-1:0]  sel_c, first_c, last_raw, last_c;
    logic            go, abort, fin, wr_en;
    logic [CHW-1:0]  wr_addr;
    logic [7:0]      wr_data, rd_data;

    // Clamp the channel select when NCH is not a power of two.
    generate
        if ((2 ** CHW) != NCH) begin : g_clamp
            always_comb sel_c = (cfg_sel > TOP_CH) ? TOP_CH : cfg_sel;
        end else begin : g_pass
            always_comb sel_c = cfg_sel;
        end
    endgenerate

    // Work out the scan range, dropping the reference channel from multi scans.
    always_comb begin
        first_c  = (cfg_scan == SCAN_UP) ? '0 : sel_c;
        last_raw = (cfg_scan == SCAN_TOP) ? TOP_CH : sel_c;
        last_c   = (cfg_ref_on && last_raw == TOP_CH && last_raw != first_c)
                   ? last_raw - 1'b1 : last_raw;
        abort    = ev_start | ev_stop;
        go       = (bst == BS_AACK) && ev_scl_fall && !abort;
    end

    srs_scan_seq #(.NCH(NCH), .TRACK_CYC(TRACK_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .go        (go),
        .first_ch  (first_c),
        .last_ch   (last_c),
        .cnv_start (cnv_start),
        .cnv_chan  (cnv_chan),
        .cnv_done  (cnv_done),
        .cnv_data  (cnv_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .fin       (fin)
    );

    srs_result_ram #(.DEPTH(NCH), .AW(CHW)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    // Bus state machine: address, acknowledge, stretch, and read-out shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || ev_stop) begin
            bst      <= BS_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            rd_ptr   <= '0;
            rd_last  <= '0;
            mack     <= 1'b0;
            scl_hold <= 1'b0;
            sda_low  <= 1'b0;
        end else if (ev_start) begin
            bst      <= BS_ADDR;
            bitcnt   <= '0;
            rd_ptr   <= '0;
            mack     <= 1'b0;
            scl_hold <= 1'b0;
            sda_low  <= 1'b0;
        end else begin
            case (bst)
                BS_ADDR: begin
                    if (ev_scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], sda_in};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev_scl_fall && bitcnt == 4'd8) begin
                        if (shreg[7:1] == DEV_ADDR && shreg[0]) begin
                            sda_low <= 1'b1;
                            bst     <= BS_AACK;
                        end else begin
                            bst <= BS_PARK;
                        end
                    end
                end
                BS_AACK: if (ev_scl_fall) begin
                    sda_low  <= 1'b0;
                    scl_hold <= 1'b1;
                    rd_last  <= last_c - first_c;
                    bst      <= BS_CONV;
                end
                BS_CONV: if (fin) begin
                    scl_hold <= 1'b0;
                    shreg    <= rd_data;
                    sda_low  <= ~rd_data[7];
                    bitcnt   <= '0;
                    bst      <= BS_READ;
                end
                BS_READ: begin
                    if (ev_scl_rise && bitcnt == 4'd8) begin
                        mack <= ~sda_in;
                        if (!sda_in)
                            rd_ptr <= (rd_ptr == rd_last) ? '0 : rd_ptr + 1'b1;
                    end else if (ev_scl_fall) begin
                        if (bitcnt < 4'd7) begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_low <= ~shreg[6];
                            bitcnt  <= bitcnt + 1'b1;
                        end else if (bitcnt == 4'd7) begin
                            sda_low <= 1'b0;
                            bitcnt  <= 4'd8;
                        end else if (mack) begin
                            shreg   <= rd_data;
                            sda_low <= ~rd_data[7];
                            bitcnt  <= '0;
                        end else begin
                            bst <= BS_PARK;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srs_checker.sv
// Port-level temporal checks for stretch_read_seq, attached by bind.
// Assumes: the same reset and clock as the checked block.
module srs_checker (
    input logic clk,
    input logic rst_n,
    input logic ev_start,
    input logic ev_stop,
    input logic ev_scl_fall,
    input logic scl_hold,
    input logic sda_low,
    input logic cnv_start,
    input logic cnv_done
);
    logic pend;

    // Track whether a conversion is open (started, no done yet).
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (cnv_start) pend <= 1'b1;
        else if (cnv_done)  pend <= 1'b0;
    end

    a_r1_hold_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> $past(ev_scl_fall));

    a_r2_convert_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> scl_hold);

    a_r2_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_hold) && !$past(ev_start) && !$past(ev_stop)) |-> !pend);

    a_r3_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start);

    a_r3_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> !pend);

    a_r6_sda_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> ($past(ev_scl_fall) || $past(ev_start)
                               || $past(ev_stop) || $fell(scl_hold)));
endmodule

bind stretch_read_seq srs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_start    (ev_start),
    .ev_stop     (ev_stop),
    .ev_scl_fall (ev_scl_fall),
    .scl_hold    (scl_hold),
    .sda_low     (sda_low),
    .cnv_start   (cnv_start),
    .cnv_done    (cnv_done)
);

// File: tb/stretch_read_seq_bench.sv
module stretch_read_seq_bench;
    localparam int         NCH   = 8;
    localparam int         TRK   = 2;
    localparam int         LAT   = 5;
    localparam logic [6:0] ADDR  = 7'h64;
    // {scan[1:0], sel[2:0], ref_on, nread[4:0]}
    localparam logic [10:0] VEC [7] = '{
        {2'b00, 3'd3, 1'b0, 5'd4},
        {2'b00, 3'd7, 1'b1, 5'd9},
        {2'b01, 3'd5, 1'b0, 5'd5},
        {2'b01, 3'd5, 1'b1, 5'd3},
        {2'b10, 3'd7, 1'b1, 5'd2},
        {2'b00, 3'd0, 1'b0, 5'd2},
        {2'b01, 3'd7, 1'b1, 5'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_scl_rise = 0, ev_scl_fall = 0, sda_in = 1;
    logic [2:0] cfg_sel = '0;
    logic [1:0] cfg_scan = '0;
    logic cfg_ref_on = 0, cnv_done = 0;
    logic [7:0] cnv_data = '0;
    logic scl_hold, sda_low, cnv_start;
    logic [2:0] cnv_chan;

    int n_chk = 0, n_bad = 0, gen = 0, nconv = 0, gap = 0;
    bit after_done = 0, finished = 0;
    int got_ch [32];

    always #5 clk = ~clk;

    stretch_read_seq #(.DEV_ADDR(ADDR), .NCH(NCH), .TRACK_CYC(TRK)) u_stretch_read_seq (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_scl_rise(ev_scl_rise), .ev_scl_fall(ev_scl_fall), .sda_in(sda_in),
        .cfg_sel(cfg_sel), .cfg_scan(cfg_scan), .cfg_ref_on(cfg_ref_on),
        .scl_hold(scl_hold), .sda_low(sda_low), .cnv_start(cnv_start),
        .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_data(cnv_data));

    function automatic logic [7:0] dfun(int g, int c);
        return 8'(g * 37 + c * 11 + 3);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Converter model: fixed latency, data from generation and channel.
    initial forever begin
        @(negedge clk);
        if (cnv_start) begin
            if (after_done) chk(gap == TRK - 1, "R3 gap", gap, TRK - 1);
            if (nconv < 32) got_ch[nconv] = int'(cnv_chan);
            nconv++;
            repeat (LAT) @(negedge clk);
            cnv_done = 1; cnv_data = dfun(gen, int'(cnv_chan));
            @(negedge clk);
            cnv_done = 0; after_done = 1; gap = 0;
        end else if (after_done) gap++;
    end

    task automatic prise(); @(negedge clk) ev_scl_rise = 1; @(negedge clk) ev_scl_rise = 0; endtask
    task automatic pfall(); @(negedge clk) ev_scl_fall = 1; @(negedge clk) ev_scl_fall = 0; endtask
    task automatic pstart(); @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0; endtask
    task automatic pstop(); @(negedge clk) ev_stop = 1; @(negedge clk) ev_stop = 0; endtask

    task automatic send_addr(input logic [7:0] b, output logic ack);
        pstart();
        for (int i = 7; i >= 0; i--) begin
            pfall(); sda_in = b[i]; prise();
        end
        pfall();
        ack = sda_low;
        sda_in = 1; prise();
    endtask

    task automatic read_byte(input bit ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            b[i] = ~sda_low; prise(); pfall();
        end
        chk(sda_low == 0, "R6 ack slot free", sda_low, 0);
        sda_in = ack ? 1'b0 : 1'b1; prise(); pfall(); sda_in = 1;
    endtask

    task automatic run_xfer(input logic [1:0] sc, input logic [2:0] sel, input bit rf,
                            input int nread, input bit nack_last);
        logic ack, c1;
        logic [7:0] b;
        int first, last, n, w;
        cfg_scan = sc; cfg_sel = sel; cfg_ref_on = rf;
        gen++; nconv = 0; after_done = 0;
        first = (sc == 2'b00) ? 0 : int'(sel);
        last  = (sc == 2'b01) ? NCH - 1 : int'(sel);
        if (rf && last == NCH - 1 && last != first) last--;
        n = last - first + 1;
        send_addr({ADDR, 1'b1}, ack);
        chk(ack == 1, "R1 ack", ack, 1);
        pfall();
        chk(scl_hold == 1, "R2 hold", scl_hold, 1);
        @(negedge clk); c1 = cnv_start;
        @(negedge clk);
        chk(!c1 && cnv_start, "R3 first start", {c1, cnv_start}, 1);
        w = 0;
        while (scl_hold && w < 5000) begin @(negedge clk); w++; end
        chk(!scl_hold, "R2 release", scl_hold, 0);
        chk(nconv == n, rf ? "R5 count" : "R4 count", nconv, n);
        for (int i = 0; i < n && i < nconv; i++)
            chk(got_ch[i] == first + i, rf ? "R5 chan" : "R4 chan", got_ch[i], first + i);
        for (int k = 0; k < nread; k++) begin
            read_byte((k < nread - 1) || !nack_last, b);
            chk(b == dfun(gen, first + (k % n)),
                (k >= n) ? "R7 wrap" : (k == 0 ? "R9 first" : "R6 byte"),
                b, dfun(gen, first + (k % n)));
        end
        if (nack_last) begin
            repeat (3) begin prise(); pfall(); end
            chk(sda_low == 0 && !scl_hold, "R8 released", sda_low, 0);
            pstop();
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected done");
            summary();
        end
    end

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!scl_hold && !sda_low && !cnv_start, "R10 reset",
            {scl_hold, sda_low, cnv_start}, 0);

        for (int v = 0; v < 7; v++)
            run_xfer(VEC[v][10:9], VEC[v][8:6], VEC[v][5], int'(VEC[v][4:0]), 1'b1);

        // R1: wrong address, then a write bit: no ack, no stretch, no conversion.
        nconv = 0;
        send_addr({ADDR ^ 7'h01, 1'b1}, ack);
        chk(ack == 0, "R1 wrong addr", ack, 0);
        pfall(); repeat (10) @(negedge clk);
        chk(!scl_hold && nconv == 0, "R1 no scan", nconv, 0);
        pstop();
        send_addr({ADDR, 1'b0}, ack);
        chk(ack == 0, "R1 write bit", ack, 0);
        pfall(); repeat (10) @(negedge clk);
        chk(!scl_hold && nconv == 0, "R1 no scan wr", nconv, 0);
        pstop();

        // R9: partial read acked, then a repeated START gives fresh data from entry 0.
        run_xfer(2'b00, 3'd3, 1'b0, 2, 1'b0);
        run_xfer(2'b00, 3'd3, 1'b0, 2, 1'b1);

        finished = 1;
        summary();
    end
endmodule